// File: doc/BRIEF.md
# Dual-Compare Programmable Timer/Counter

This block is a 16-bit up-counter with two compare limits and one output pin. It advances once per timer event. An event comes either from a fixed service slot that recurs every fourth clock, or from a rising edge on an external clock input. That input is synchronized and then applied at the next service slot. An optional gate input can hold off counting. When the count would reach the active limit, it goes straight back to zero in the same update. A limit value therefore never appears in the count register.

In single-limit mode the output pin idles high and drops low for one clock after each wrap. In alternating mode each wrap hands control to the other limit register. The pin then shows which register is in control, so the two limits set the high and low times of a square wave.

Software reaches four words through one small register port: count, primary limit, secondary limit and control. The count can be read or overwritten at any moment, whether the timer is running or stopped.

Top module: `dual_max_timer`

## Requirements
- R1: After reset the count, both limit registers and the control word read as zero, and the output is high.
- R2: Word 0 holds the count, word 1 the primary limit, word 2 the secondary limit and word 3 the control. A write to word 0 loads the count whether the timer is running or stopped; the new value reads back in the next cycle and wins over an event in the same cycle.
- R3: Each timer event adds one to the count. When the incremented value equals the active limit, the count becomes 0 instead, so the limit value is never held. A limit of 0 gives a full 65536-event cycle (0xFFFF wraps to 0).
- R4: Control bit 1 selects alternating mode. In that mode every wrap switches the active limit between primary and secondary. Control read bit 4 reports the active register (0 = primary, 1 = secondary) and stays 0 outside alternating mode.
- R5: In single-limit mode the output goes low for exactly one clock following each wrap and is high otherwise.
- R6: In alternating mode the output is high while the primary limit is active and low while the secondary is active.
- R7: With control bit 2 clear, events come from the internal service slot: exactly one event in every four clocks while the timer runs.
- R8: With control bit 2 set, each synchronized rising edge of the external clock is one event, applied at a service slot. The count rises at most once per four clocks, and it responds no later than six clocks after the input edge.
- R9: With control bit 3 set, events are counted only while the synchronized gate input is high.
- R10: With control bit 0 clear, the count is frozen and the output is held high.
- R11: Any write to the control word makes the primary limit active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word select for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected word |
| ext_clk_in | input | 1 | Asynchronous external event clock |
| gate_in | input | 1 | Asynchronous count gate |
| tmr_out | output | 1 | Timer output pin |

## Verification
Output-waveform checks use a table that pairs single-limit and alternating modes with both short and long limits. Counting low clocks over a whole number of periods separates a one-clock pulse from a level that follows the active register. It also exposes a wrong period or a swapped limit. The count is sampled with a small limit, with a limit of zero from 0xFFFE, and after a write during counting. These cases separate a wrap that lands on the limit from one that holds it, and a write that wins from one that loses to an event. External edges are applied both slowly and every other clock, which separates edge counting from the four-clock rate limit. Single edges are timed to bound the response delay.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    typedef enum logic [1:0] {
        WORD_COUNT = 2'd0,
        WORD_PLIM  = 2'd1,
        WORD_SLIM  = 2'd2,
        WORD_CTRL  = 2'd3
    } word_sel_e;

    // control word, bit 0 upward: run, alternate, external source, gate enable
    typedef struct packed {
        logic gate_en;
        logic ext_src;
        logic alt;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_BITS  = 4;
    localparam int unsigned STATUS_BIT = 4;

    function automatic logic [STATUS_BIT:0] ctrl_view(input ctrl_t c, input logic sec_active);
        return {sec_active, c};
    endfunction

endpackage

// File: rtl/tmr_sync.sv
`timescale 1ns/1ps
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/tmr_slot.sv
`timescale 1ns/1ps
module tmr_slot #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic slot
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign slot = (phase == LAST);
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slot,
    input  logic         ext_rise,
    input  logic         gate_lvl,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] plim,
    input  logic [W-1:0] slim,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         ctrl_we,
    output logic [W-1:0] count,
    output logic         sec_active,
    output logic         out
);
    logic         pend;
    logic         src_hit;
    logic         gate_ok;
    logic         evt;
    logic         wrap;
    logic         sec_next;
    logic [W-1:0] cur_lim;
    logic [W-1:0] inc;

    assign src_hit = ctrl.ext_src ? (ext_rise | pend) : 1'b1;
    assign gate_ok = ~ctrl.gate_en | gate_lvl;
    assign evt     = ctrl.run & slot & src_hit & gate_ok;
    assign cur_lim = sec_active ? slim : plim;
    assign inc     = count + 1'b1;
    assign wrap    = evt & (inc == cur_lim);

    always_comb begin
        sec_next = sec_active;
        if (ctrl_we)               sec_next = 1'b0;
        else if (wrap && ctrl.alt) sec_next = ~sec_active;
    end

    // an edge seen between slots waits for the next slot
    always_ff @(posedge clk) begin
        if (rst)                          pend <= 1'b0;
        else if (!ctrl.run || !ctrl.ext_src) pend <= 1'b0;
        else if (slot)                    pend <= 1'b0;
        else if (ext_rise)                pend <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (cnt_we)  count <= cnt_wdata;
        else if (evt)     count <= wrap ? '0 : inc;
    end

    always_ff @(posedge clk) begin
        if (rst) sec_active <= 1'b0;
        else     sec_active <= sec_next;
    end

    always_ff @(posedge clk) begin
        if (rst)            out <= 1'b1;
        else if (!ctrl.run) out <= 1'b1;
        else if (ctrl.alt)  out <= ~sec_next;
        else                out <= ~wrap;
    end
endmodule

// File: rtl/dual_max_timer.sv
`timescale 1ns/1ps
module dual_max_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_LEN  = 2,
    parameter int SLOT_DIV  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ext_clk_in,
    input  logic             gate_in,
    output logic             tmr_out
);
    localparam int VIEW_W = STATUS_BIT + 1;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] plim_q;
    logic [CNT_W-1:0] slim_q;
    logic [CNT_W-1:0] count_q;
    logic             sec_q;
    logic             slot;
    logic             ext_lvl;
    logic             ext_rise;
    logic             gate_lvl;
    logic             gate_rise;
    logic             cnt_we;
    logic             ctrl_we;
    logic             run_w;
    logic             alt_w;
    word_sel_e        sel;

    assign sel     = word_sel_e'(bus_addr);
    assign cnt_we  = bus_we && (sel == WORD_COUNT);
    assign ctrl_we = bus_we && (sel == WORD_CTRL);
    assign run_w   = ctrl_q.run;
    assign alt_w   = ctrl_q.alt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            plim_q <= '0;
            slim_q <= '0;
        end else if (bus_we) begin
            unique case (sel)
                WORD_PLIM: plim_q <= bus_wdata;
                WORD_SLIM: slim_q <= bus_wdata;
                WORD_CTRL: ctrl_q <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
                default:   ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            WORD_COUNT: bus_rdata = count_q;
            WORD_PLIM:  bus_rdata = plim_q;
            WORD_SLIM:  bus_rdata = slim_q;
            default:    bus_rdata = CNT_W'(ctrl_view(ctrl_q, sec_q));
        endcase
    end

    tmr_sync #(.STAGES(SYNC_LEN)) u_ext_sync (
        .clk(clk), .rst(rst), .din(ext_clk_in), .level(ext_lvl), .rise(ext_rise)
    );

    tmr_sync #(.STAGES(SYNC_LEN)) u_gate_sync (
        .clk(clk), .rst(rst), .din(gate_in), .level(gate_lvl), .rise(gate_rise)
    );

    tmr_slot #(.DIV(SLOT_DIV)) u_slot (
        .clk(clk), .rst(rst), .slot(slot)
    );

    tmr_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .slot(slot), .ext_rise(ext_rise),
        .gate_lvl(gate_lvl), .ctrl(ctrl_q), .plim(plim_q), .slim(slim_q),
        .cnt_we(cnt_we), .cnt_wdata(bus_wdata), .ctrl_we(ctrl_we),
        .count(count_q), .sec_active(sec_q), .out(tmr_out)
    );

    logic unused_ok;
    assign unused_ok = ext_lvl ^ gate_rise;
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         wr,
    input logic         slot,
    input logic         run,
    input logic         alt,
    input logic         sec,
    input logic [W-1:0] count,
    input logic [W-1:0] plim,
    input logic [W-1:0] slim,
    input logic         out
);
    logic [W-1:0] cmax;
    assign cmax = sec ? slim : plim;

    a_r3_limit_never_held: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr) && $past(count != cmax) && cmax != '0) |-> count != cmax);

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        !$past(wr) |-> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

    a_r7_moves_on_slot: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr) && count != $past(count)) |-> $past(slot));

    a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
        $past(!run) |-> out);

    a_r5_one_clock_low: assert property (@(posedge clk) disable iff (rst)
        (run && !alt && !out) |=> out);

    a_r4_sec_needs_alt: assert property (@(posedge clk) disable iff (rst)
        !alt |-> !sec);
endmodule

bind dual_max_timer tmr_checker #(.W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .wr(bus_we), .slot(slot), .run(run_w), .alt(alt_w),
    .sec(sec_q), .count(count_q), .plim(plim_q), .slim(slim_q), .out(tmr_out)
);

// File: tb/dual_max_timer_test.sv
`timescale 1ns/1ps
module dual_max_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_clk_in = 1'b0;
    logic        gate_in = 1'b0;
    logic        tmr_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dual_max_timer uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk_in(ext_clk_in), .gate_in(gate_in), .tmr_out(tmr_out)
    );

    typedef struct packed {
        logic        alt;
        logic [15:0] plim;
        logic [15:0] slim;
        logic [15:0] lows;
    } vec_t;

    // low clocks over a 128-clock window (whole periods)
    localparam vec_t VECS [7] = '{
        '{1'b0, 16'd4, 16'd0, 16'd8},
        '{1'b0, 16'd8, 16'd0, 16'd4},
        '{1'b0, 16'd2, 16'd0, 16'd16},
        '{1'b1, 16'd3, 16'd5, 16'd80},
        '{1'b1, 16'd1, 16'd1, 16'd64},
        '{1'b1, 16'd2, 16'd6, 16'd96},
        '{1'b1, 16'd5, 16'd3, 16'd48}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #4000000;
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v, c0, c1;
        int lows, maxseen, bad, runlen;
        bit seen0, seen1;

        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        rd(2'd0, v); check(v == 0, "R1 count", v, 0);
        rd(2'd1, v); check(v == 0, "R1 plim", v, 0);
        rd(2'd2, v); check(v == 0, "R1 slim", v, 0);
        rd(2'd3, v); check(v == 0, "R1 ctrl", v, 0);
        check(tmr_out == 1'b1, "R1 out", tmr_out, 1);

        // R2 register access while stopped
        wr(2'd0, 16'h1234); rd(2'd0, v); check(v == 16'h1234, "R2 count rw", v, 16'h1234);
        wr(2'd1, 16'hBEEF); rd(2'd1, v); check(v == 16'hBEEF, "R2 plim rw", v, 16'hBEEF);

        // R10 stopped: frozen, high
        wr(2'd0, 16'd7);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            if (!tmr_out) bad++;
        end
        rd(2'd0, v); check(v == 7, "R10 frozen", v, 7);
        check(bad == 0, "R10 out high", bad, 0);

        // R7 internal rate: 10 events per 40 clocks
        wr(2'd1, 16'd0); wr(2'd0, 16'd100); wr(2'd3, 16'h0001);
        rd(2'd0, c0); tick(40); rd(2'd0, c1);
        check(c1 == c0 + 16'd10, "R7 rate", c1, c0 + 10);

        // R2 write while running wins, then one event per 4 clocks
        wr(2'd0, 16'h0200); rd(2'd0, v); check(v == 16'h0200, "R2 running write", v, 16'h0200);
        tick(4); rd(2'd0, v); check(v == 16'h0201, "R2 resumes", v, 16'h0201);

        // R3 wrap with limit 5
        wr(2'd3, 16'h0000); wr(2'd1, 16'd5); wr(2'd0, 16'd0); wr(2'd3, 16'h0001);
        bad = 0; maxseen = 0;
        bus_addr = 2'd0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #1;
            if (bus_rdata >= 5) bad++;
            if (bus_rdata > maxseen) maxseen = bus_rdata;
        end
        check(bad == 0, "R3 limit never held", bad, 0);
        check(maxseen == 4, "R3 top value", maxseen, 4);
        rd(2'd0, c0); tick(20); rd(2'd0, c1);
        check(c1 == c0, "R3 period 5", c1, c0);

        // R3 limit 0 is a full cycle
        wr(2'd3, 16'h0000); wr(2'd1, 16'd0); wr(2'd0, 16'hFFFE); wr(2'd3, 16'h0001);
        tick(8); rd(2'd0, v); check(v == 0, "R3 wrap at 0xFFFF", v, 0);

        // R5/R6/R4 waveform table
        foreach (VECS[k]) begin
            wr(2'd3, 16'h0000);
            wr(2'd0, 16'd0);
            wr(2'd1, VECS[k].plim);
            wr(2'd2, VECS[k].slim);
            wr(2'd3, VECS[k].alt ? 16'h0003 : 16'h0001);
            bus_addr = 2'd3;
            tick(40);
            lows = 0; bad = 0; runlen = 0; seen0 = 0; seen1 = 0;
            for (int i = 0; i < 128; i++) begin
                @(negedge clk); #1;
                if (!tmr_out) begin lows++; runlen++; end else runlen = 0;
                if (!VECS[k].alt && runlen > 1) bad++;
                if (VECS[k].alt && (tmr_out != !bus_rdata[4])) bad++;
                if (!VECS[k].alt && bus_rdata[4]) bad++;
                if (bus_rdata[4]) seen1 = 1; else seen0 = 1;
            end
            if (VECS[k].alt) begin
                check(lows == VECS[k].lows, "R6 low time", lows, VECS[k].lows);
                check(bad == 0, "R6 out tracks active", bad, 0);
                check(seen0 && seen1, "R4 status alternates", {seen1, seen0}, 3);
            end else begin
                check(lows == VECS[k].lows, "R5 pulse count", lows, VECS[k].lows);
                check(bad == 0, "R5 one clock low", bad, 0);
            end
        end

        // R11 control write restores primary (limits 3/5 alternating)
        wr(2'd3, 16'h0000); wr(2'd0, 16'd0); wr(2'd1, 16'd3); wr(2'd2, 16'd5);
        wr(2'd3, 16'h0003);
        bus_addr = 2'd3;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1;
            if (bus_rdata[4]) break;
        end
        rd(2'd3, v); check(v[4] == 1'b1, "R11 reached secondary", v[4], 1);
        wr(2'd3, 16'h0003);
        rd(2'd3, v); check(v[4] == 1'b0, "R11 status primary", v[4], 0);
        check(tmr_out == 1'b1, "R11 out high", tmr_out, 1);

        // R9 gate
        wr(2'd3, 16'h0000); wr(2'd1, 16'd0); wr(2'd0, 16'd0);
        gate_in = 1'b0;
        wr(2'd3, 16'h0009);
        tick(40); rd(2'd0, v); check(v == 0, "R9 gated off", v, 0);
        gate_in = 1'b1; tick(5);
        rd(2'd0, c0); tick(40); rd(2'd0, c1);
        check(c1 == c0 + 16'd10, "R9 gated on", c1, c0 + 10);

        // R8 external slow edges
        wr(2'd3, 16'h0000); wr(2'd0, 16'd0); gate_in = 1'b0;
        wr(2'd3, 16'h0005);
        tick(4);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ext_clk_in = 1'b1; tick(6);
            ext_clk_in = 1'b0; tick(6);
        end
        tick(10);
        rd(2'd0, v); check(v == 5, "R8 edge count", v, 5);

        // R8 latency
        rd(2'd0, c0);
        @(negedge clk); ext_clk_in = 1'b1;
        runlen = 99;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk); #1;
            if (bus_rdata != c0) begin runlen = i; break; end
        end
        check(runlen <= 6, "R8 latency", runlen, 6);
        tick(4); ext_clk_in = 1'b0; tick(8);

        // R8 rate limit with edges every other clock
        rd(2'd0, c0);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk); ext_clk_in = ~ext_clk_in;
        end
        ext_clk_in = 1'b0; tick(10);
        rd(2'd0, c1);
        v = c1 - c0;
        check(v >= 18 && v <= 23, "R8 rate limit", v, 20);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule